// File: doc/BRIEF.md
# Memory Pattern Read-Back Checker

This block is the checking half of a memory self-test. A start pulse makes it read back a contiguous region of memory and compare each returned word against a deterministic test pattern. It tallies the words that disagree. It does not keep the stored data: it recomputes each expected word from that word's position in the region. Because of this, a writer that filled the region with the same pattern function can be verified with no storage beyond a few registers.

The block issues reads through a valid/ready command channel and accepts data from a plain valid-qualified return path. It keeps only one read in flight at a time. Data words may be any multiple of 32 bits wide. Each 32-bit slice of the expected word is computed from its own sub-seed. The pattern can be scrambled by a multiplicative hash or left as a plain count. When the last word has been compared, `done` rises and the mismatch total stays readable on `err_count` until the next start.

Top module: `mem_pattern_checker`

## Requirements
- R1: While `rst` is high and after it is released, `done` is 0, `cmd_valid` is 0 and `err_count` is 0 until a start is accepted.
- R2: After a start with base B and length L, exactly L read commands are issued, the k-th (k = 0..L-1) carrying address B+k, in increasing order.
- R3: With `scramble` = 1 sampled at start, the expected 32-bit value for sub-seed s is (s × 0x31415979 + 1) mod 2^32.
- R4: With `scramble` = 0 sampled at start, the expected 32-bit value for sub-seed s is s itself.
- R5: For DATA_W = 32·N, the expected word k is N slices concatenated, where slice i (i = 0..N-1) uses sub-seed k·N+i and slice 0 occupies the most significant 32 bits.
- R6: `err_count` clears to 0 when a start is accepted and rises by exactly one for each returned word that differs from its expected word in any number of bits.
- R7: `err_count` saturates at 2^ERR_W − 1 and never wraps.
- R8: Once `cmd_valid` is high, it holds with a stable `cmd_addr` until `cmd_ready`. After a handshake, no new command appears until read data has returned.
- R9: `done` is low from the cycle after an accepted start until the last word has been compared. It then stays high, with `err_count` unchanged, until the next accepted start.
- R10: A start with length 0 raises `done` with no read command issued and `err_count` = 0.
- R11: A start pulse that arrives while a check is in progress is ignored. The running check completes with its original base and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse |
| scramble | input | 1 | Pattern mode, sampled at start: 1 hashed, 0 plain count |
| base | input | ADDR_W | First word address of the region, sampled at start |
| length | input | LEN_W | Number of words to check, sampled at start |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Read command accepted |
| cmd_addr | output | ADDR_W | Read command word address |
| rd_valid | input | 1 | Returned read data valid |
| rd_data | input | DATA_W | Returned read data |
| done | output | 1 | Check finished |
| err_count | output | ERR_W | Number of mismatching words |

## Verification
The bench builds the block with DATA_W = 64. This gives two slices per word, so slice order and sub-seed numbering (R5) show up as distinct failures when the halves are swapped. ERR_W is set to 3, so the counter reaches its ceiling of 7 within a dozen words and saturation (R7) becomes visible in a short run. The memory model varies its command-accept delay and read latency from one request to the next. This exercises the command-hold rule and the single outstanding read.

// File: rtl/mem_pattern_checker.sv
module mem_pattern_checker #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int DATA_W = 64,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              scramble,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  length,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ERR_W-1:0]  err_count
);
  localparam int          NS   = DATA_W / 32;
  localparam logic [31:0] MULT = 32'h31415979;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q, idx;
  logic              scr_q;
  logic [ERR_W-1:0]  errs;
  logic [DATA_W-1:0] expect_w;
  logic              mismatch, last;

  function automatic logic [DATA_W-1:0] pattern(input logic [LEN_W-1:0] k, input logic scr);
    logic [DATA_W-1:0] w;
    logic [31:0]       seed;
    w = '0;
    for (int i = 0; i < NS; i++) begin
      seed = 32'(k) * 32'(NS) + 32'(i);
      if (scr) seed = seed * MULT + 32'd1;
      w[DATA_W-1-32*i -: 32] = seed;
    end
    return w;
  endfunction

  assign expect_w  = pattern(idx, scr_q);
  assign mismatch  = rd_data != expect_w;
  assign last      = idx == len_q - LEN_W'(1);
  assign cmd_valid = st == S_REQ;
  assign cmd_addr  = base_q + ADDR_W'(idx);
  assign done      = st == S_DONE;
  assign err_count = errs;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      base_q <= '0;
      len_q  <= '0;
      scr_q  <= 1'b0;
      idx    <= '0;
      errs   <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          base_q <= base;
          len_q  <= length;
          scr_q  <= scramble;
          idx    <= '0;
          errs   <= '0;
          st     <= (length == '0) ? S_DONE : S_REQ;
        end
        S_REQ: if (cmd_ready) st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          if (mismatch && errs != '1) errs <= errs + ERR_W'(1);
          if (last) st <= S_DONE;
          else begin
            idx <= idx + LEN_W'(1);
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mem_pattern_checker_chk #(
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rd_valid,
  input logic              done,
  input logic [ERR_W-1:0]  err_count
);
  logic in_flight;
  always_ff @(posedge clk) begin
    if (rst) in_flight <= 1'b0;
    else if (cmd_valid && cmd_ready) in_flight <= 1'b1;
    else if (rd_valid) in_flight <= 1'b0;
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));
  // R8
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !cmd_valid);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(err_count));
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);
  // R6
  err_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> err_count >= $past(err_count));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !done && !cmd_valid && err_count == '0);
endmodule

bind mem_pattern_checker mem_pattern_checker_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) chk_i (.*);

// File: tb/mem_pattern_checker_tb.sv
module mem_pattern_checker_tb_top;
  localparam int ADDR_W = 16, LEN_W = 12, DATA_W = 64, ERR_W = 3;

  logic clk = 0, rst = 1, start = 0, scramble = 0;
  logic [ADDR_W-1:0] base = '0;
  logic [LEN_W-1:0]  length = '0;
  logic cmd_valid, cmd_ready, rd_valid, done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [ERR_W-1:0]  err_count;

  always #2 clk = ~clk;

  mem_pattern_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .scramble(scramble), .base(base), .length(length),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err_count(err_count));

  int tests = 0, fails = 0, cycles = 0;
  logic [DATA_W-1:0] mem [64];
  logic [ADDR_W-1:0] alog [256];
  int nlog = 0;
  logic pend = 0;
  logic [ADDR_W-1:0] paddr = '0;
  int wcnt = 0, lat = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    cmd_ready <= 1'b0;
    rd_valid  <= 1'b0;
    if (rst) begin
      pend <= 0; wcnt <= 0; lat <= 0; rd_data <= '0;
    end else if (cmd_valid && cmd_ready) begin
      pend <= 1; paddr <= cmd_addr; lat <= nlog % 2; wcnt <= (nlog + 1) % 3;
      alog[nlog % 256] <= cmd_addr; nlog <= nlog + 1;
    end else if (pend) begin
      if (lat == 0) begin rd_valid <= 1'b1; rd_data <= mem[paddr[5:0]]; pend <= 0; end
      else lat <= lat - 1;
    end else if (cmd_valid) begin
      if (wcnt == 0) cmd_ready <= 1'b1; else wcnt <= wcnt - 1;
    end
  end

  initial begin
    cmd_ready = 0; rd_valid = 0; rd_data = '0;
  end

  function automatic logic [63:0] expw(int k, bit scr);
    logic [31:0] a, b;
    a = 32'(2 * k); b = 32'(2 * k + 1);
    if (scr) begin a = a * 32'h31415979 + 32'd1; b = b * 32'h31415979 + 32'd1; end
    return {a, b};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic fill(int b, int n, bit scr);
    for (int k = 0; k < n; k++) mem[(b + k) % 64] = expw(k, scr);
  endtask

  task automatic launch(int b, int n, bit scr);
    @(negedge clk);
    base = ADDR_W'(b); length = LEN_W'(n); scramble = scr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) check(0, "R9 timeout", 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 0, "R1 done", done, 0);
    check(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    check(err_count == 0, "R1 err_count", err_count, 0);
  endtask

  task automatic t_scrambled();
    int n0 = nlog;
    fill(8, 12, 1);
    launch(8, 12, 1);
    check(done == 0, "R9 low during run", done, 0);
    wait_done();
    check(err_count == 0, "R3 R5 scrambled clean", err_count, 0);
    check(nlog - n0 == 12, "R2 read count", nlog - n0, 12);
    for (int k = 0; k < 12; k++)
      check(alog[(n0 + k) % 256] == ADDR_W'(8 + k), "R2 address order", alog[(n0 + k) % 256], 8 + k);
  endtask

  task automatic t_plain();
    fill(20, 6, 0);
    launch(20, 6, 0);
    wait_done();
    check(err_count == 0, "R4 plain clean", err_count, 0);
    launch(20, 5, 1);
    wait_done();
    check(err_count == 5, "R6 one per word mode mismatch", err_count, 5);
  endtask

  task automatic t_slices();
    fill(30, 8, 1);
    mem[32] = {mem[32][31:0], mem[32][63:32]};
    mem[35] = mem[35] ^ 64'hFF00_0000_0000_00FF;
    launch(30, 8, 1);
    wait_done();
    check(err_count == 2, "R5 R6 swapped and multi-bit", err_count, 2);
  endtask

  task automatic t_saturate();
    fill(40, 12, 1);
    for (int k = 0; k < 12; k++) mem[40 + k] = ~mem[40 + k];
    launch(40, 12, 1);
    wait_done();
    check(err_count == 7, "R7 saturation", err_count, 7);
    fill(40, 12, 1);
    launch(40, 12, 1);
    wait_done();
    check(err_count == 0, "R6 clear on start", err_count, 0);
  endtask

  task automatic t_zero();
    int n0 = nlog;
    launch(5, 0, 1);
    repeat (3) @(negedge clk);
    check(done == 1, "R10 done", done, 1);
    check(nlog == n0, "R10 no reads", nlog - n0, 0);
    check(err_count == 0, "R10 err_count", err_count, 0);
  endtask

  task automatic t_hold();
    logic [ERR_W-1:0] e;
    fill(8, 4, 1);
    mem[9] = '0;
    launch(8, 4, 1);
    wait_done();
    e = err_count;
    check(e == 1, "R6 single error", e, 1);
    repeat (20) @(negedge clk);
    check(done == 1, "R9 done held", done, 1);
    check(err_count == e, "R9 err stable", err_count, e);
  endtask

  task automatic t_busy();
    int n0 = nlog;
    fill(8, 10, 1);
    launch(8, 10, 1);
    repeat (4) @(negedge clk);
    base = 16'd50; length = 12'd2; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    check(nlog - n0 == 10, "R11 read count", nlog - n0, 10);
    check(alog[(n0 + 9) % 256] == 16'd17, "R11 last address", alog[(n0 + 9) % 256], 17);
    check(err_count == 0, "R11 err_count", err_count, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_reset();
    t_scrambled();
    t_plain();
    t_slices();
    t_saturate();
    t_zero();
    t_hold();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    tests++; fails++;
    $display("FAIL R9 watchdog actual=%0d expected=0", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule